// File: doc/BRIEF.md
# Serial Display-Word Loader with Masked Multi-Word Write

This block receives a bit-serial stream and stores its column payload into a small display memory of eight 40-bit words. The stream is clocked by a serial clock. Each frame carries column data first and a one-hot write-enable mask last. When the strobe falls, the payload is written into every word whose mask bit is set. A mask of all zeros writes nothing, so a strobe can resynchronise chained devices without changing their contents. A scan engine fetches one word per display row through a combinational read port.

Two frame formats exist. In row-and-column mode a frame is 40 bits long. The last `MUX` bits (`MUX` is 2, 4 or 8) form the mask, and the other `40-MUX` bits are column data. In column-only mode a frame is 48 bits long: 40 column bits and an 8-bit mask, whatever `MUX` is. A serial output repeats the input one frame length later, so several devices can be chained. The host sends the data for the farthest device first.

All inputs must be synchronous to `clk`. Serial clock edges and the strobe's falling edge are found by comparing each input with its value on the previous `clk` edge.

Top module: `lcdl_serial_loader`

## Requirements
- R1: Synchronous active-high reset clears the shift register and drives `sdo_o` low. For the first frame length of serial clocks after reset, `sdo_o` stays low whatever `sdi_i` carries.
- R2: On the `clk` edge where a falling serial-clock edge is seen, `sdi_i` is shifted into the shift register. A serial-clock rise does not shift.
- R3: `sdo_o` changes only on the `clk` edge where a rising serial-clock edge is seen. In row-and-column mode (`col_only_i`=0) it then shows the bit that entered 40 shifts earlier.
- R4: In column-only mode (`col_only_i`=1), `sdo_o` shows the bit that entered 48 shifts earlier.
- R5: Frame bits are numbered 1 to N, where N is the frame length. Bit N is sent first and bit 1 last. In row-and-column mode, bits 1..MUX are mask bits, and bit k drives the enable of word k-1. Bits MUX+1..40 are stored right-aligned: bit MUX+1 goes to word bit 0, and the top MUX word bits are written as 0.
- R6: In column-only mode, bits 1..8 are mask bits, and bit k enables word k-1. Bits 9..48 are stored as word bits 0..39.
- R7: In one strobe, every word whose mask bit is set receives the same payload.
- R8: A strobe with an all-zero mask leaves every word unchanged.
- R9: The write happens on the `clk` edge where the strobe's fall is seen. While the strobe rises or is held high, no word changes.
- R10: `rd_word_o` shows the word selected by `rd_row_i` in the same cycle, with no clock edge needed.
- R11: In row-and-column mode, words MUX..7 are never written, even when the stream bits that sit in those mask positions in column-only mode are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| col_only_i | input | 1 | 1 selects the 48-bit column-only frame, 0 selects the 40-bit row-and-column frame |
| sclk_i | input | 1 | Serial clock, sampled by `clk` |
| sdi_i | input | 1 | Serial data in |
| stb_i | input | 1 | Strobe; its falling edge commits the write |
| sdo_o | output | 1 | Serial data out for chaining, registered |
| rd_row_i | input | 3 | Word index for the scan read |
| rd_word_o | output | 40 | Display word selected by `rd_row_i` |

## Verification
The assertions check every cycle that the shift register and `sdo_o` hold their values between the qualifying serial-clock edges. They also check that a word changes only when a strobe fall meets its mask bit. In row-and-column mode they check that words at or above MUX stay untouched and that a written word carries zeros in its top MUX bits. Only the bench scenarios can show the exact field layout, the 40- and 48-shift delays on the chained output, the multi-word and empty-mask writes, and that holding the strobe high writes nothing.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;
  localparam int WORD_W     = 40;
  localparam int COL_MASK_W = 8;
  localparam int NUM_WORDS  = 8;
  localparam int ROW_FRAME  = WORD_W;
  localparam int COL_FRAME  = WORD_W + COL_MASK_W;
  localparam int ROW_IDX_W  = $clog2(NUM_WORDS);

  typedef logic [WORD_W-1:0]     word_t;
  typedef logic [NUM_WORDS-1:0]  mask_t;
endpackage

// File: rtl/lcdl_edge.sv
module lcdl_edge #(
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse_o = prev_q & ~sig_i;
    end else begin : g_rise
      assign pulse_o = ~prev_q & sig_i;
    end
  endgenerate
endmodule

// File: rtl/lcdl_shifter.sv
module lcdl_shifter #(
  parameter int ROW_LEN = 40,
  parameter int COL_LEN = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en_i,
  input  logic               tap_en_i,
  input  logic               col_only_i,
  input  logic               sdi_i,
  output logic [COL_LEN-1:0] sr_o,
  output logic               sdo_o
);
  logic [COL_LEN-1:0] sr_q;
  logic               sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (shift_en_i) sr_q <= {sr_q[COL_LEN-2:0], sdi_i};
      if (tap_en_i)   sdo_q <= col_only_i ? sr_q[COL_LEN-1] : sr_q[ROW_LEN-1];
    end
  end

  assign sr_o  = sr_q;
  assign sdo_o = sdo_q;

  AST_SHIFT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !shift_en_i |=> $stable(sr_q)); // R2
  AST_SDO_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !tap_en_i |=> $stable(sdo_q)); // R3
endmodule

// File: rtl/lcdl_field_split.sv
module lcdl_field_split #(
  parameter int MUX     = 8,
  parameter int WORD_W  = 40,
  parameter int MASK_W  = 8,
  parameter int COL_LEN = 48
) (
  input  logic               col_only_i,
  input  logic [COL_LEN-1:0] sr_i,
  output logic [MASK_W-1:0]  mask_o,
  output logic [WORD_W-1:0]  payload_o
);
  logic [WORD_W-1:0] row_payload;
  logic [WORD_W-1:0] col_payload;

  // Row mode: the mask occupies the low MUX positions; the columns above it
  // are moved down so the word is right-aligned with zeros on top.
  assign row_payload = sr_i[WORD_W-1:0] >> MUX;
  assign col_payload = sr_i[COL_LEN-1:MASK_W];

  // The mask field is always the last MASK_W bits received; positions above
  // MUX are blocked by the store when in row mode.
  assign mask_o    = sr_i[MASK_W-1:0];
  assign payload_o = col_only_i ? col_payload : row_payload;
endmodule

// File: rtl/lcdl_word_store.sv
module lcdl_word_store #(
  parameter int MUX       = 8,
  parameter int WORD_W    = 40,
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 row_mode_i,
  input  logic [NUM_WORDS-1:0] mask_i,
  input  logic [WORD_W-1:0]    payload_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [WORD_W-1:0]    rd_word_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam bit ROW_OK = (i < MUX);
    logic we;

    assign we = wr_i & mask_i[i] & (ROW_OK | ~row_mode_i);

    always_ff @(posedge clk) begin
      if (we) mem_q[i] <= payload_i;
    end

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr_i && mask_i[i]) |=> (mem_q[i] === $past(mem_q[i]))); // R9

    if (ROW_OK) begin : g_row_word
      AST_ROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_i && mask_i[i] && row_mode_i) |=> (mem_q[i][WORD_W-1 -: MUX] == '0)); // R5
    end else begin : g_col_word
      AST_ROW_WORD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_i && row_mode_i) |=> (mem_q[i] === $past(mem_q[i]))); // R11
    end
  end

  assign rd_word_o = mem_q[rd_idx_i];
endmodule

// File: rtl/lcdl_serial_loader.sv
module lcdl_serial_loader
  import lcdl_pkg::*;
#(
  parameter int MUX = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 col_only_i,
  input  logic                 sclk_i,
  input  logic                 sdi_i,
  input  logic                 stb_i,
  output logic                 sdo_o,
  input  logic [ROW_IDX_W-1:0] rd_row_i,
  output logic [WORD_W-1:0]    rd_word_o
);
  logic                 sclk_fall;
  logic                 sclk_rise;
  logic                 stb_fall;
  logic [COL_FRAME-1:0] sr;
  mask_t                mask;
  word_t                payload;

  lcdl_edge #(.FALLING(1'b1)) i_sclk_fall (
    .clk(clk), .rst(rst), .sig_i(sclk_i), .pulse_o(sclk_fall)
  );
  lcdl_edge #(.FALLING(1'b0)) i_sclk_rise (
    .clk(clk), .rst(rst), .sig_i(sclk_i), .pulse_o(sclk_rise)
  );
  lcdl_edge #(.FALLING(1'b1)) i_stb_fall (
    .clk(clk), .rst(rst), .sig_i(stb_i), .pulse_o(stb_fall)
  );

  lcdl_shifter #(.ROW_LEN(ROW_FRAME), .COL_LEN(COL_FRAME)) i_shifter (
    .clk(clk), .rst(rst),
    .shift_en_i(sclk_fall), .tap_en_i(sclk_rise),
    .col_only_i(col_only_i), .sdi_i(sdi_i),
    .sr_o(sr), .sdo_o(sdo_o)
  );

  lcdl_field_split #(
    .MUX(MUX), .WORD_W(WORD_W), .MASK_W(COL_MASK_W), .COL_LEN(COL_FRAME)
  ) i_split (
    .col_only_i(col_only_i), .sr_i(sr), .mask_o(mask), .payload_o(payload)
  );

  lcdl_word_store #(
    .MUX(MUX), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(ROW_IDX_W)
  ) i_store (
    .clk(clk), .rst(rst),
    .wr_i(stb_fall), .row_mode_i(~col_only_i),
    .mask_i(mask), .payload_i(payload),
    .rd_idx_i(rd_row_i), .rd_word_o(rd_word_o)
  );
endmodule

// File: tb/test_lcdl_serial_loader.sv
module test_lcdl_serial_loader;
  localparam int MUXB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        col_only = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        stb = 1'b0;
  logic        sdo;
  logic [2:0]  rd_row = '0;
  logic [39:0] rd_word;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lcdl_serial_loader #(.MUX(MUXB)) i_lcdl_serial_loader (
    .clk(clk), .rst(rst), .col_only_i(col_only), .sclk_i(sclk), .sdi_i(sdi),
    .stb_i(stb), .sdo_o(sdo), .rd_row_i(rd_row), .rd_word_o(rd_word)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [47:0] fr, input int len,
                            output logic [47:0] dor, output logic [47:0] dof);
    dor = '0;
    dof = '0;
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); sdi = fr[i]; sclk = 1'b1;
      @(negedge clk); dor[i] = sdo; sclk = 1'b0;
      @(negedge clk); dof[i] = sdo;
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk); stb = 1'b1;
    @(negedge clk);
    @(negedge clk); stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_check(input string req, input int row, input logic [39:0] exp);
    @(negedge clk); rd_row = 3'(row);
    #1 check(req, {8'h0, rd_word}, {8'h0, exp});
  endtask

  task automatic t_reset();
    logic [47:0] r, f;
    check("R1 sdo after reset", {47'h0, sdo}, 48'h0);
    col_only = 1'b0;
    send_frame(48'h00FF_FFFF_FFFF, 40, r, f);
    check("R1 sdo low over first frame", r, 48'h0);
  endtask

  task automatic t_row_write();
    logic [47:0] r, f;
    col_only = 1'b0;
    send_frame({8'h0, 36'h9A5C31F0E, 4'b0101}, 40, r, f);
    pulse_strobe();
    read_check("R2 R5 R7 row word0", 0, {4'h0, 36'h9A5C31F0E});
    read_check("R5 R7 row word2", 2, {4'h0, 36'h9A5C31F0E});
  endtask

  task automatic t_sdo_row();
    logic [47:0] r, f;
    logic [47:0] a = 48'h00C3_5A96_0F1E;
    col_only = 1'b0;
    send_frame(a, 40, r, f);
    send_frame(48'h0012_3456_789A, 40, r, f);
    check("R3 sdo 40-shift delay", {8'h0, r[39:0]}, {8'h0, a[39:0]});
    check("R3 sdo stable on sclk fall", f, r);
  endtask

  task automatic t_col_write();
    logic [47:0] r, f;
    col_only = 1'b1;
    send_frame({40'hDEADBEEF01, 8'b1100_0010}, 48, r, f);
    pulse_strobe();
    read_check("R6 R7 col word7", 7, 40'hDEADBEEF01);
    read_check("R6 R7 col word6", 6, 40'hDEADBEEF01);
    read_check("R6 R7 col word1", 1, 40'hDEADBEEF01);
    read_check("R7 unmasked word0 kept", 0, {4'h0, 36'h9A5C31F0E});
  endtask

  task automatic t_sdo_col();
    logic [47:0] r, f;
    logic [47:0] a = 48'hA1B2_C3D4_E5F6;
    col_only = 1'b1;
    send_frame(a, 48, r, f);
    send_frame(48'h5555_AAAA_0F0F, 48, r, f);
    check("R4 sdo 48-shift delay", r, a);
    check("R4 sdo stable on sclk fall", f, r);
  endtask

  task automatic t_zero_mask();
    logic [47:0] r, f;
    col_only = 1'b1;
    send_frame({40'h123456789A, 8'h00}, 48, r, f);
    pulse_strobe();
    read_check("R8 word0 kept", 0, {4'h0, 36'h9A5C31F0E});
    read_check("R8 word1 kept", 1, 40'hDEADBEEF01);
    read_check("R8 word2 kept", 2, {4'h0, 36'h9A5C31F0E});
    read_check("R8 word7 kept", 7, 40'hDEADBEEF01);
  endtask

  task automatic t_strobe_edge();
    logic [47:0] r, f;
    col_only = 1'b1;
    send_frame({40'h0F0F0F0F0F, 8'h02}, 48, r, f);
    @(negedge clk); stb = 1'b1;
    repeat (3) @(negedge clk);
    read_check("R9 no write while strobe high", 1, 40'hDEADBEEF01);
    @(negedge clk); stb = 1'b0;
    @(negedge clk);
    read_check("R9 write on strobe fall", 1, 40'h0F0F0F0F0F);
  endtask

  task automatic t_read_port();
    @(negedge clk); rd_row = 3'd6;
    #1 check("R10 read row6", {8'h0, rd_word}, {8'h0, 40'hDEADBEEF01});
    #2 rd_row = 3'd0;
    #1 check("R10 read row0 without clock", {8'h0, rd_word}, {8'h0, 4'h0, 36'h9A5C31F0E});
  endtask

  task automatic t_row_limit();
    logic [47:0] r, f;
    col_only = 1'b0;
    send_frame(48'h00FF_FFFF_FFFF, 40, r, f);
    pulse_strobe();
    for (int w = 0; w < MUXB; w++)
      read_check("R5 R11 row word written", w, {4'h0, 36'hFFFFFFFFF});
    read_check("R11 word6 locked in row mode", 6, 40'hDEADBEEF01);
    read_check("R11 word7 locked in row mode", 7, 40'hDEADBEEF01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_row_write();
    t_sdo_row();
    t_col_write();
    t_sdo_col();
    t_zero_mask();
    t_strobe_edge();
    t_read_port();
    t_row_limit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule